// File: doc/BRIEF.md
# Shared Memory Block Access Guard

This block decides, access by access, whether a requester may touch one of a bank of shared memory blocks that sit between two processor subsystems, A and B. Each subsystem has a CPU port and a DMA port, giving four requester identities. Every block has one ownership bit. The owner's CPU may read, write and fetch instructions from the block, and the owner's DMA may read and write it. The other subsystem may only read.

Only subsystem A's CPU can program the ownership map. After reset, subsystem A owns every block, and software on A's CPU hands blocks over to B by setting their bits. Each request carries the requester identity, an access kind and a block index. The permission check is combinational, and one cycle later the block answers with either a grant or a violation pulse. A violation names the requester and the block. A write that is denied never raises the write enable towards the memory array.

Top module: `shram_access_guard`

## Requirements
- R1: After reset the ownership map reads all zeros, so subsystem A owns every block, and `gnt`, `viol` and `mem_we` are low.
- R2: When `cfg_wr_en` is high with `cfg_src` = 0 (A's CPU), `own_map` takes the value of `cfg_wdata` at that clock edge. In a map bit, 0 means subsystem A owns the block and 1 means B owns it.
- R3: A map write with any other `cfg_src` (1 = A's DMA, 2 = B's CPU, 3 = B's DMA) leaves `own_map` unchanged.
- R4: A read (`req_kind` = 0) to an in-range block is granted to all four requesters, whoever owns the block.
- R5: The owner's CPU (source 0 or 2, matching the owner) is granted writes (`req_kind` = 1) and fetches (`req_kind` = 2).
- R6: The owner's DMA (source 1 or 3, matching the owner) is granted writes and denied fetches.
- R7: Writes and fetches from either port of the subsystem that does not own the block are denied.
- R8: `req_kind` = 3 is reserved and is always denied. A block index at or above `NUM_BLK` is denied for every kind, reads included.
- R9: The response appears in the cycle after the request. A valid request gives exactly one of `gnt` or `viol` for one cycle. Without a request, both stay low.
- R10: While `viol` is high, `viol_src` and `viol_blk` equal the identity and block index of the denied request. Both read zero when `viol` is low.
- R11: `mem_we` is high exactly when a granted write is being answered, so a denied write never reaches the memory.
- R12: A request made in the same cycle as a map write is judged against the map as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_src | input | 2 | Requester: 0 A CPU, 1 A DMA, 2 B CPU, 3 B DMA |
| req_kind | input | 2 | Access: 0 read, 1 write, 2 fetch, 3 reserved |
| req_blk | input | BLK_W (4) | Target block index |
| cfg_wr_en | input | 1 | Ownership map write strobe |
| cfg_src | input | 2 | Identity of the map writer |
| cfg_wdata | input | NUM_BLK (12) | New ownership map |
| own_map | output | NUM_BLK (12) | Current ownership map |
| gnt | output | 1 | Registered grant |
| viol | output | 1 | Registered one-cycle violation pulse |
| viol_src | output | 2 | Requester of the denied access |
| viol_blk | output | BLK_W (4) | Block of the denied access |
| mem_we | output | 1 | Write enable to the memory array |

## Verification
A wrong ownership bit shows up at the ports one cycle after the next write or fetch to that block: the response flips between grant and violation, and `own_map` shows the bad bit as soon as the edge has passed. A bad permission decision for a requester and kind shows at once on `gnt`, `viol` and `mem_we` in the following cycle. The bench's behavioural RAM turns a leaked write into corrupted data. Map writes from non-A sources are mixed into the random traffic, so a write that should have been ignored but was not is caught through `own_map` right away, and again through later decisions.

// File: rtl/shram_pkg.sv
package shram_pkg;

  typedef enum logic [1:0] {
    SRC_CPU_A = 2'd0,
    SRC_DMA_A = 2'd1,
    SRC_CPU_B = 2'd2,
    SRC_DMA_B = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    ACC_RD    = 2'd0,
    ACC_WR    = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  // Subsystem a requester belongs to: 0 = A, 1 = B.
  function automatic logic side_of(logic [1:0] src);
    return src[1];
  endfunction

  // Requester is a DMA port.
  function automatic logic is_dma(logic [1:0] src);
    return src[0];
  endfunction

  // Rights of a requester on a block, given which subsystem owns it.
  function automatic logic rights_ok(logic [1:0] src, logic [1:0] kind,
                                     logic owner_b);
    logic owns;
    owns = (side_of(src) == owner_b);
    case (acc_e'(kind))
      ACC_RD:    rights_ok = 1'b1;
      ACC_WR:    rights_ok = owns;
      ACC_FETCH: rights_ok = owns && !is_dma(src);
      default:   rights_ok = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/shram_own_reg.sv
module shram_own_reg #(
  parameter int NUM_BLK = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [1:0]         cfg_src,
  input  logic [NUM_BLK-1:0] cfg_wdata,
  output logic [NUM_BLK-1:0] own_map
);
  import shram_pkg::*;

  // Only subsystem A's CPU may reprogram ownership.
  logic cfg_accept;
  assign cfg_accept = cfg_wr_en && (src_e'(cfg_src) == SRC_CPU_A);

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          own_map[b] <= 1'b0;
      else if (cfg_accept) own_map[b] <= cfg_wdata[b];
    end
  end

  AST_OWN_RESET_A: assert property (@(posedge clk)
    $rose(rst_n) |-> own_map == '0);                                        // R1
  AST_OWN_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en && cfg_src != 2'd0 |=> $stable(own_map));                     // R3
  AST_OWN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en && cfg_src == 2'd0 |=> own_map == $past(cfg_wdata));          // R2

endmodule

// File: rtl/shram_perm_eval.sv
module shram_perm_eval #(
  parameter int NUM_BLK = 12,
  parameter int BLK_W   = 4
) (
  input  logic               req_valid,
  input  logic [1:0]         req_src,
  input  logic [1:0]         req_kind,
  input  logic [BLK_W-1:0]   req_blk,
  input  logic [NUM_BLK-1:0] own_map,
  output logic               grant_c,
  output logic               deny_c,
  output logic               wr_grant_c
);
  import shram_pkg::*;

  localparam int            BLK_SPAN = 1 << BLK_W;
  localparam logic [BLK_W:0] BLK_LIMIT = (BLK_W+1)'(NUM_BLK);

  logic [BLK_SPAN-1:0] map_padded;
  logic                in_range;
  logic                owner_b;
  logic                allowed;

  assign map_padded = BLK_SPAN'(own_map);
  assign in_range   = ({1'b0, req_blk} < BLK_LIMIT);
  assign owner_b    = map_padded[req_blk];
  assign allowed    = in_range && rights_ok(req_src, req_kind, owner_b);

  assign grant_c    = req_valid && allowed;
  assign deny_c     = req_valid && !allowed;
  assign wr_grant_c = grant_c && (acc_e'(req_kind) == ACC_WR);

  AST_EVAL_EXCL: assert final (!(grant_c && deny_c));                       // R9
  AST_EVAL_RSVD: assert final (!(req_valid && req_kind == 2'd3) || deny_c); // R8

endmodule

// File: rtl/shram_resp_reg.sv
module shram_resp_reg #(
  parameter int BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant_c,
  input  logic             deny_c,
  input  logic             wr_grant_c,
  input  logic [1:0]       req_src,
  input  logic [BLK_W-1:0] req_blk,
  output logic             gnt,
  output logic             viol,
  output logic [1:0]       viol_src,
  output logic [BLK_W-1:0] viol_blk,
  output logic             mem_we
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt      <= 1'b0;
      viol     <= 1'b0;
      viol_src <= '0;
      viol_blk <= '0;
      mem_we   <= 1'b0;
    end else begin
      gnt      <= grant_c;
      viol     <= deny_c;
      viol_src <= deny_c ? req_src : '0;
      viol_blk <= deny_c ? req_blk : '0;
      mem_we   <= wr_grant_c;
    end
  end

  AST_WE_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> gnt);                                                        // R11
  AST_VIOL_INFO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !viol |-> viol_src == 2'd0 && viol_blk == '0);                          // R10

endmodule

// File: rtl/shram_access_guard.sv
module shram_access_guard #(
  parameter int NUM_BLK = 12,
  parameter int BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_src,
  input  logic [1:0]         req_kind,
  input  logic [BLK_W-1:0]   req_blk,
  input  logic               cfg_wr_en,
  input  logic [1:0]         cfg_src,
  input  logic [NUM_BLK-1:0] cfg_wdata,
  output logic [NUM_BLK-1:0] own_map,
  output logic               gnt,
  output logic               viol,
  output logic [1:0]         viol_src,
  output logic [BLK_W-1:0]   viol_blk,
  output logic               mem_we
);

  // Internal events, named for the assertions.
  logic grant_c;
  logic deny_c;
  logic wr_grant_c;

  shram_own_reg #(.NUM_BLK(NUM_BLK)) u_own (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_src   (cfg_src),
    .cfg_wdata (cfg_wdata),
    .own_map   (own_map)
  );

  shram_perm_eval #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_eval (
    .req_valid  (req_valid),
    .req_src    (req_src),
    .req_kind   (req_kind),
    .req_blk    (req_blk),
    .own_map    (own_map),
    .grant_c    (grant_c),
    .deny_c     (deny_c),
    .wr_grant_c (wr_grant_c)
  );

  shram_resp_reg #(.BLK_W(BLK_W)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant_c    (grant_c),
    .deny_c     (deny_c),
    .wr_grant_c (wr_grant_c),
    .req_src    (req_src),
    .req_blk    (req_blk),
    .gnt        (gnt),
    .viol       (viol),
    .viol_src   (viol_src),
    .viol_blk   (viol_blk),
    .mem_we     (mem_we)
  );

  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (gnt ^ viol));                                            // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !gnt && !viol);                                          // R9
  AST_DMA_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 2'd2 && req_src[0] |=> viol);                  // R6
  AST_READ_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 2'd0 && {1'b0, req_blk} < (BLK_W+1)'(NUM_BLK)
    |=> gnt);                                                               // R4
  AST_VIOL_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !grant_c |=> viol_src == $past(req_src)
                              && viol_blk == $past(req_blk));               // R10

endmodule

// File: tb/shram_access_guard_tb_top.sv
module shram_access_guard_tb_top;
  localparam int NB = 12;
  localparam int BW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_src = '0;
  logic [1:0]    req_kind = '0;
  logic [BW-1:0] req_blk = '0;
  logic          cfg_wr_en = 1'b0;
  logic [1:0]    cfg_src = '0;
  logic [NB-1:0] cfg_wdata = '0;
  logic [NB-1:0] own_map;
  logic          gnt, viol, mem_we;
  logic [1:0]    viol_src;
  logic [BW-1:0] viol_blk;

  int n_chk = 0;
  int n_fail = 0;
  logic [NB-1:0] mdl_map = '0;
  logic [7:0]    ram [16];

  always #2 clk = ~clk;

  shram_access_guard #(.NUM_BLK(NB), .BLK_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
    .req_kind(req_kind), .req_blk(req_blk), .cfg_wr_en(cfg_wr_en),
    .cfg_src(cfg_src), .cfg_wdata(cfg_wdata), .own_map(own_map),
    .gnt(gnt), .viol(viol), .viol_src(viol_src), .viol_blk(viol_blk),
    .mem_we(mem_we)
  );

  // Bench view of the rules: who may do what.
  function automatic bit exp_allow(int src, int kind, int blk, logic [NB-1:0] m);
    bit b_owns, dma;
    if (blk >= NB) return 0;
    b_owns = m[blk];
    dma    = (src == 1) || (src == 3);
    if (kind == 0) return 1;
    if (kind == 3) return 0;
    if ((src >= 2) != b_owns) return 0;
    if (kind == 2 && dma) return 0;
    return 1;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One request, optionally together with a map write; checks the response.
  task automatic access(int src, int kind, int blk, bit do_cfg, int csrc,
                        logic [NB-1:0] cdata, string tag);
    bit ok;
    logic [7:0] wval;
    @(negedge clk);
    req_valid = 1'b1; req_src = 2'(src); req_kind = 2'(kind); req_blk = BW'(blk);
    cfg_wr_en = do_cfg; cfg_src = 2'(csrc); cfg_wdata = cdata;
    ok = exp_allow(src, kind, blk, mdl_map);
    if (do_cfg && csrc == 0) mdl_map = cdata;
    wval = 8'($urandom);
    @(posedge clk);
    #1;
    req_valid = 1'b0; cfg_wr_en = 1'b0;
    if (mem_we) ram[blk] = wval;
    check({tag, " gnt"}, gnt, ok);
    check({tag, " viol R9"}, viol, !ok);
    check({tag, " viol_src R10"}, viol_src, ok ? 0 : src);
    check({tag, " viol_blk R10"}, viol_blk, ok ? 0 : blk);
    check({tag, " mem_we R11"}, mem_we, ok && kind == 1);
    check({tag, " own_map R2/R3"}, own_map, mdl_map);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) ram[i] = 8'h00;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 own_map", own_map, 0);
    check("R1 gnt", gnt, 0);
    check("R1 viol", viol, 0);
    check("R1 mem_we", mem_we, 0);

    // R4 reads by all, R5 A CPU write/fetch, R6 A DMA fetch denied
    for (int s = 0; s < 4; s++) access(s, 0, 3, 0, 0, '0, "R4 read");
    access(0, 1, 5, 0, 0, '0, "R5 cpu write");
    access(0, 2, 5, 0, 0, '0, "R5 cpu fetch");
    access(1, 1, 5, 0, 0, '0, "R6 dma write");
    access(1, 2, 5, 0, 0, '0, "R6 dma fetch");
    // R7 non-owner
    ram[7] = 8'h5A;
    access(2, 1, 7, 0, 0, '0, "R7 B cpu write");
    check("R11 ram untouched", ram[7], 8'h5A);
    access(3, 2, 7, 0, 0, '0, "R7 B dma fetch");
    // R8 reserved kind and out of range
    access(0, 3, 1, 0, 0, '0, "R8 reserved");
    access(2, 0, 12, 0, 0, '0, "R8 range read");
    access(0, 1, 15, 0, 0, '0, "R8 range write");
    // R3 foreign map writes ignored
    access(0, 0, 0, 1, 1, 12'hFFF, "R3 dma_a cfg");
    access(0, 0, 0, 1, 2, 12'hFFF, "R3 cpu_b cfg");
    access(0, 0, 0, 1, 3, 12'hFFF, "R3 dma_b cfg");
    // R12 same-cycle write judged by old map, then R2 effect
    access(2, 1, 4, 1, 0, 12'h010, "R12 old map");
    access(2, 1, 4, 0, 0, '0, "R2 new owner write");
    access(2, 2, 4, 0, 0, '0, "R5 B cpu fetch");
    access(3, 2, 4, 0, 0, '0, "R6 B dma fetch");
    access(0, 1, 4, 0, 0, '0, "R7 A cpu write");
    // R9 idle cycle gives no response
    @(negedge clk);
    @(posedge clk); #1;
    check("R9 idle gnt", gnt, 0);
    check("R9 idle viol", viol, 0);

    // Random traffic with occasional map writes
    for (int i = 0; i < 400; i++) begin
      bit dc;
      dc = ($urandom % 8) == 0;
      access($urandom % 4, $urandom % 4, $urandom % 16, dc, $urandom % 4,
             NB'($urandom), "rand R4-R8");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule